// File: doc/BRIEF.md
# Transaction-Locked Command Stream Arbiter

This block lets two independent command-stream sources share one command execution engine for a serial peripheral bus. Each source port and the engine port carry four valid/ready channels: 16-bit command words and transmit data travel toward the engine. Receive data and an 8-bit sync response travel back from the engine to whichever source currently owns it.

Ownership is decided by a fixed priority: source 0 wins over source 1 when both are waiting. Once granted, a source keeps the engine for its whole transaction, however many commands that takes. It gives the engine up only after it has issued a synchronisation command and the engine has returned the matching sync response. A higher-priority request that arrives mid-transaction therefore waits, and a multi-command transfer on the bus is never split.

The transmit data width is a parameter (8 to 256). The receive bus is as wide as the transmit width times the number of receive lanes (1 to 8). All logic runs on one clock with a synchronous active-low reset.

Top module: `cmd_stream_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after it, no source is granted. All engine-side valids and readies are low, and all source-side readies and valids driven by the block are low. Reset applied mid-transaction also returns the block to this state.
- R2: With no source granted, a source that raises its command valid becomes the owner at the next rising clock edge. Its command then appears on the engine port in the following cycle.
- R3: When both sources have command valid high while no source is granted, source 0 is granted. Source 1 is granted only after source 0 releases.
- R4: While a source is granted, ownership does not change on non-sync commands, even if the other source is requesting.
- R5: A command is a sync command when bits [15:12] equal 4'b0011. A sync response handshake before a sync command has been accepted does not release the grant. Accepting a sync command does not release it either.
- R6: After a sync command has been accepted, the grant is released by the edge that samples a sync-response handshake (valid and ready both high) on the engine port. The next grant is taken at the following edge.
- R7: Command words and transmit data of the owner reach the engine unchanged. Receive data and sync-response data from the engine reach the owner unchanged. The owner's readies and valids follow the engine side.
- R8: A source that is not granted sees ready low on its command and transmit channels and valid low on its receive and sync-response channels. None of its valids reach the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src0_cmd_valid | input | 1 | Source 0 command valid (also its request) |
| src0_cmd_ready | output | 1 | Source 0 command ready |
| src0_cmd_data | input | 16 | Source 0 command word |
| src0_tx_valid | input | 1 | Source 0 transmit data valid |
| src0_tx_ready | output | 1 | Source 0 transmit data ready |
| src0_tx_data | input | DATA_W | Source 0 transmit data |
| src0_rx_valid | output | 1 | Source 0 receive data valid |
| src0_rx_ready | input | 1 | Source 0 receive data ready |
| src0_rx_data | output | DATA_W*RX_LANES | Source 0 receive data |
| src0_done_valid | output | 1 | Source 0 sync response valid |
| src0_done_ready | input | 1 | Source 0 sync response ready |
| src0_done_data | output | 8 | Source 0 sync response value |
| src1_cmd_valid | input | 1 | Source 1 command valid (also its request) |
| src1_cmd_ready | output | 1 | Source 1 command ready |
| src1_cmd_data | input | 16 | Source 1 command word |
| src1_tx_valid | input | 1 | Source 1 transmit data valid |
| src1_tx_ready | output | 1 | Source 1 transmit data ready |
| src1_tx_data | input | DATA_W | Source 1 transmit data |
| src1_rx_valid | output | 1 | Source 1 receive data valid |
| src1_rx_ready | input | 1 | Source 1 receive data ready |
| src1_rx_data | output | DATA_W*RX_LANES | Source 1 receive data |
| src1_done_valid | output | 1 | Source 1 sync response valid |
| src1_done_ready | input | 1 | Source 1 sync response ready |
| src1_done_data | output | 8 | Source 1 sync response value |
| eng_cmd_valid | output | 1 | Engine command valid |
| eng_cmd_ready | input | 1 | Engine command ready |
| eng_cmd_data | output | 16 | Engine command word |
| eng_tx_valid | output | 1 | Engine transmit data valid |
| eng_tx_ready | input | 1 | Engine transmit data ready |
| eng_tx_data | output | DATA_W | Engine transmit data |
| eng_rx_valid | input | 1 | Engine receive data valid |
| eng_rx_ready | output | 1 | Engine receive data ready |
| eng_rx_data | input | DATA_W*RX_LANES | Engine receive data |
| eng_done_valid | input | 1 | Engine sync response valid |
| eng_done_ready | output | 1 | Engine sync response ready |
| eng_done_data | input | 8 | Engine sync response value |

## Verification
On every cycle, the assertions check that an idle arbiter grants on a request and favours source 0. They also check that the owner stays fixed until a sync response completes a drained transaction, that release follows that handshake, and that an ungranted source is fully silenced. Only the bench's scenarios can show the end-to-end sequences. These are the near-miss opcodes that must not count as sync, and a stray sync response before the sync command. They also include the one idle cycle between release and the waiting source's grant, and the data values arriving intact at the right port for each combination of requester order, contention and transaction length.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
  localparam int CMD_W  = 16;
  localparam int DONE_W = 8;
  localparam int OP_W   = 4;
  localparam logic [OP_W-1:0] OP_SYNC = 4'b0011;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OWN   = 2'd1,
    ST_DRAIN = 2'd2
  } arb_state_e;

  function automatic logic is_sync(input logic [CMD_W-1:0] word);
    return word[CMD_W-1 -: OP_W] == OP_SYNC;
  endfunction
endpackage

// File: rtl/cmd_arb_pick.sv
module cmd_arb_pick #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] pick,
  output logic               any
);
  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) pick = NUM_SRC'(1) << i;
    end
  end
  assign any = |req;
endmodule

// File: rtl/cmd_arb_lock.sv
module cmd_arb_lock
  import cmd_arb_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               cmd_hs,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               done_hs,
  output logic [NUM_SRC-1:0] own
);
  arb_state_e          st_q;
  logic [NUM_SRC-1:0]  own_q;
  logic [NUM_SRC-1:0]  pick;
  logic                any_req;

  cmd_arb_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req  (req),
    .pick (pick),
    .any  (any_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      own_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_req) begin
          own_q <= pick;
          st_q  <= ST_OWN;
        end
        ST_OWN: if (cmd_hs && is_sync(cmd_word)) st_q <= ST_DRAIN;
        ST_DRAIN: if (done_hs) begin
          own_q <= '0;
          st_q  <= ST_IDLE;
        end
        default: begin
          own_q <= '0;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign own = own_q;

  AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && |req) |=> (|own_q)); // R2
  AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req[0]) |=> own_q[0]); // R3
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !(st_q == ST_DRAIN && done_hs)) |=> $stable(own_q)); // R4
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_q)); // R8
  AST_SYNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OWN && cmd_hs && is_sync(cmd_word)) |=> (|own_q)); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && done_hs) |=> (own_q == '0)); // R6
endmodule

// File: rtl/cmd_arb_route.sv
module cmd_arb_route
  import cmd_arb_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int DATA_W  = 8,
  parameter int RX_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             own,
  input  logic [NUM_SRC-1:0]             src_cmd_valid,
  output logic [NUM_SRC-1:0]             src_cmd_ready,
  input  logic [NUM_SRC-1:0][CMD_W-1:0]  src_cmd_data,
  input  logic [NUM_SRC-1:0]             src_tx_valid,
  output logic [NUM_SRC-1:0]             src_tx_ready,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] src_tx_data,
  output logic [NUM_SRC-1:0]             src_rx_valid,
  input  logic [NUM_SRC-1:0]             src_rx_ready,
  output logic [NUM_SRC-1:0][RX_W-1:0]   src_rx_data,
  output logic [NUM_SRC-1:0]             src_done_valid,
  input  logic [NUM_SRC-1:0]             src_done_ready,
  output logic [NUM_SRC-1:0][DONE_W-1:0] src_done_data,
  output logic                           eng_cmd_valid,
  input  logic                           eng_cmd_ready,
  output logic [CMD_W-1:0]               eng_cmd_data,
  output logic                           eng_tx_valid,
  input  logic                           eng_tx_ready,
  output logic [DATA_W-1:0]              eng_tx_data,
  input  logic                           eng_rx_valid,
  output logic                           eng_rx_ready,
  input  logic [RX_W-1:0]                eng_rx_data,
  input  logic                           eng_done_valid,
  output logic                           eng_done_ready,
  input  logic [DONE_W-1:0]              eng_done_data
);
  always_comb begin
    eng_cmd_valid  = 1'b0;
    eng_cmd_data   = '0;
    eng_tx_valid   = 1'b0;
    eng_tx_data    = '0;
    eng_rx_ready   = 1'b0;
    eng_done_ready = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (own[i]) begin
        eng_cmd_valid  = src_cmd_valid[i];
        eng_cmd_data   = src_cmd_data[i];
        eng_tx_valid   = src_tx_valid[i];
        eng_tx_data    = src_tx_data[i];
        eng_rx_ready   = src_rx_ready[i];
        eng_done_ready = src_done_ready[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_cmd_ready[g]  = own[g] & eng_cmd_ready;
    assign src_tx_ready[g]   = own[g] & eng_tx_ready;
    assign src_rx_valid[g]   = own[g] & eng_rx_valid;
    assign src_rx_data[g]    = own[g] ? eng_rx_data : '0;
    assign src_done_valid[g] = own[g] & eng_done_valid;
    assign src_done_data[g]  = own[g] ? eng_done_data : '0;

    AST_UNOWNED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !own[g] |-> !(src_cmd_ready[g] || src_tx_ready[g] || src_rx_valid[g] || src_done_valid[g])); // R8
  end

  AST_IDLE_ENGINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (own == '0) |-> !(eng_cmd_valid || eng_tx_valid || eng_rx_ready || eng_done_ready)); // R1
endmodule

// File: rtl/cmd_stream_arbiter.sv
module cmd_stream_arbiter
  import cmd_arb_pkg::*;
#(
  parameter int  DATA_W   = 8,
  parameter int  RX_LANES = 1,
  localparam int RX_W     = DATA_W * RX_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src0_cmd_valid,
  output logic              src0_cmd_ready,
  input  logic [15:0]       src0_cmd_data,
  input  logic              src0_tx_valid,
  output logic              src0_tx_ready,
  input  logic [DATA_W-1:0] src0_tx_data,
  output logic              src0_rx_valid,
  input  logic              src0_rx_ready,
  output logic [RX_W-1:0]   src0_rx_data,
  output logic              src0_done_valid,
  input  logic              src0_done_ready,
  output logic [7:0]        src0_done_data,
  input  logic              src1_cmd_valid,
  output logic              src1_cmd_ready,
  input  logic [15:0]       src1_cmd_data,
  input  logic              src1_tx_valid,
  output logic              src1_tx_ready,
  input  logic [DATA_W-1:0] src1_tx_data,
  output logic              src1_rx_valid,
  input  logic              src1_rx_ready,
  output logic [RX_W-1:0]   src1_rx_data,
  output logic              src1_done_valid,
  input  logic              src1_done_ready,
  output logic [7:0]        src1_done_data,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [15:0]       eng_cmd_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic [RX_W-1:0]   eng_rx_data,
  input  logic              eng_done_valid,
  output logic              eng_done_ready,
  input  logic [7:0]        eng_done_data
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0]             own;
  logic [NUM_SRC-1:0]             s_cmd_valid, s_cmd_ready;
  logic [NUM_SRC-1:0][CMD_W-1:0]  s_cmd_data;
  logic [NUM_SRC-1:0]             s_tx_valid, s_tx_ready;
  logic [NUM_SRC-1:0][DATA_W-1:0] s_tx_data;
  logic [NUM_SRC-1:0]             s_rx_valid, s_rx_ready;
  logic [NUM_SRC-1:0][RX_W-1:0]   s_rx_data;
  logic [NUM_SRC-1:0]             s_done_valid, s_done_ready;
  logic [NUM_SRC-1:0][DONE_W-1:0] s_done_data;

  assign s_cmd_valid  = {src1_cmd_valid, src0_cmd_valid};
  assign s_cmd_data   = {src1_cmd_data, src0_cmd_data};
  assign s_tx_valid   = {src1_tx_valid, src0_tx_valid};
  assign s_tx_data    = {src1_tx_data, src0_tx_data};
  assign s_rx_ready   = {src1_rx_ready, src0_rx_ready};
  assign s_done_ready = {src1_done_ready, src0_done_ready};

  assign {src1_cmd_ready, src0_cmd_ready}   = s_cmd_ready;
  assign {src1_tx_ready, src0_tx_ready}     = s_tx_ready;
  assign {src1_rx_valid, src0_rx_valid}     = s_rx_valid;
  assign {src1_rx_data, src0_rx_data}       = s_rx_data;
  assign {src1_done_valid, src0_done_valid} = s_done_valid;
  assign {src1_done_data, src0_done_data}   = s_done_data;

  cmd_arb_lock #(.NUM_SRC(NUM_SRC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (s_cmd_valid),
    .cmd_hs   (eng_cmd_valid & eng_cmd_ready),
    .cmd_word (eng_cmd_data),
    .done_hs  (eng_done_valid & eng_done_ready),
    .own      (own)
  );

  cmd_arb_route #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RX_W(RX_W)) u_route (
    .clk            (clk),
    .rst_n          (rst_n),
    .own            (own),
    .src_cmd_valid  (s_cmd_valid),
    .src_cmd_ready  (s_cmd_ready),
    .src_cmd_data   (s_cmd_data),
    .src_tx_valid   (s_tx_valid),
    .src_tx_ready   (s_tx_ready),
    .src_tx_data    (s_tx_data),
    .src_rx_valid   (s_rx_valid),
    .src_rx_ready   (s_rx_ready),
    .src_rx_data    (s_rx_data),
    .src_done_valid (s_done_valid),
    .src_done_ready (s_done_ready),
    .src_done_data  (s_done_data),
    .eng_cmd_valid  (eng_cmd_valid),
    .eng_cmd_ready  (eng_cmd_ready),
    .eng_cmd_data   (eng_cmd_data),
    .eng_tx_valid   (eng_tx_valid),
    .eng_tx_ready   (eng_tx_ready),
    .eng_tx_data    (eng_tx_data),
    .eng_rx_valid   (eng_rx_valid),
    .eng_rx_ready   (eng_rx_ready),
    .eng_rx_data    (eng_rx_data),
    .eng_done_valid (eng_done_valid),
    .eng_done_ready (eng_done_ready),
    .eng_done_data  (eng_done_data)
  );
endmodule

// File: tb/cmd_stream_arbiter_tb.sv
`timescale 1ns/100ps
module cmd_stream_arbiter_tb;
  localparam int DATA_W   = 8;
  localparam int RX_LANES = 2;
  localparam int RX_W     = DATA_W * RX_LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              s_cmd_v [0:1];
  logic [15:0]       s_cmd_d [0:1];
  logic              s_cmd_r [0:1];
  logic              s_tx_v  [0:1];
  logic [DATA_W-1:0] s_tx_d  [0:1];
  logic              s_tx_r  [0:1];
  logic              s_rx_v  [0:1];
  logic              s_rx_r  [0:1];
  logic [RX_W-1:0]   s_rx_d  [0:1];
  logic              s_dn_v  [0:1];
  logic              s_dn_r  [0:1];
  logic [7:0]        s_dn_d  [0:1];

  logic              e_cmd_v, e_cmd_r = 1'b1;
  logic [15:0]       e_cmd_d;
  logic              e_tx_v, e_tx_r = 1'b1;
  logic [DATA_W-1:0] e_tx_d;
  logic              e_rx_v = 1'b0, e_rx_r;
  logic [RX_W-1:0]   e_rx_d = '0;
  logic              e_dn_v = 1'b0, e_dn_r;
  logic [7:0]        e_dn_d = '0;

  cmd_stream_arbiter #(.DATA_W(DATA_W), .RX_LANES(RX_LANES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .src0_cmd_valid(s_cmd_v[0]), .src0_cmd_ready(s_cmd_r[0]), .src0_cmd_data(s_cmd_d[0]),
    .src0_tx_valid(s_tx_v[0]), .src0_tx_ready(s_tx_r[0]), .src0_tx_data(s_tx_d[0]),
    .src0_rx_valid(s_rx_v[0]), .src0_rx_ready(s_rx_r[0]), .src0_rx_data(s_rx_d[0]),
    .src0_done_valid(s_dn_v[0]), .src0_done_ready(s_dn_r[0]), .src0_done_data(s_dn_d[0]),
    .src1_cmd_valid(s_cmd_v[1]), .src1_cmd_ready(s_cmd_r[1]), .src1_cmd_data(s_cmd_d[1]),
    .src1_tx_valid(s_tx_v[1]), .src1_tx_ready(s_tx_r[1]), .src1_tx_data(s_tx_d[1]),
    .src1_rx_valid(s_rx_v[1]), .src1_rx_ready(s_rx_r[1]), .src1_rx_data(s_rx_d[1]),
    .src1_done_valid(s_dn_v[1]), .src1_done_ready(s_dn_r[1]), .src1_done_data(s_dn_d[1]),
    .eng_cmd_valid(e_cmd_v), .eng_cmd_ready(e_cmd_r), .eng_cmd_data(e_cmd_d),
    .eng_tx_valid(e_tx_v), .eng_tx_ready(e_tx_r), .eng_tx_data(e_tx_d),
    .eng_rx_valid(e_rx_v), .eng_rx_ready(e_rx_r), .eng_rx_data(e_rx_d),
    .eng_done_valid(e_dn_v), .eng_done_ready(e_dn_r), .eng_done_data(e_dn_d)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_srcs();
    for (int i = 0; i < 2; i++) begin
      s_cmd_v[i] = 1'b0; s_cmd_d[i] = '0;
      s_tx_v[i] = 1'b0;  s_tx_d[i] = '0;
      s_rx_r[i] = 1'b0;  s_dn_r[i] = 1'b0;
    end
    e_rx_v = 1'b0; e_dn_v = 1'b0;
  endtask

  // own = -1 means no source may be granted
  task automatic chk_owner(input int own, input string req);
    #1;
    if (own < 0) begin
      chk(req, "idle eng_cmd_valid", e_cmd_v, 0);
      chk(req, "idle eng_tx_valid", e_tx_v, 0);
      chk(req, "idle eng_rx_ready", e_rx_r, 0);
      chk(req, "idle eng_done_ready", e_dn_r, 0);
      for (int i = 0; i < 2; i++) begin
        chk(req, "idle src cmd_ready", s_cmd_r[i], 0);
        chk(req, "idle src tx_ready", s_tx_r[i], 0);
        chk(req, "idle src rx_valid", s_rx_v[i], 0);
        chk(req, "idle src done_valid", s_dn_v[i], 0);
      end
    end else begin
      chk(req, "eng_cmd_valid", e_cmd_v, s_cmd_v[own]);
      if (s_cmd_v[own]) chk(req, "R7 eng_cmd_data", e_cmd_d, s_cmd_d[own]);
      chk(req, "owner cmd_ready", s_cmd_r[own], e_cmd_r);
      chk(req, "eng_tx_valid", e_tx_v, s_tx_v[own]);
      if (s_tx_v[own]) chk(req, "R7 eng_tx_data", e_tx_d, s_tx_d[own]);
      chk(req, "owner tx_ready", s_tx_r[own], e_tx_r);
      chk(req, "owner rx_valid", s_rx_v[own], e_rx_v);
      chk(req, "owner done_valid", s_dn_v[own], e_dn_v);
      chk(req, "eng_done_ready", e_dn_r, s_dn_r[own]);
      chk(req, "eng_rx_ready", e_rx_r, s_rx_r[own]);
      chk("R8", "other cmd_ready", s_cmd_r[1-own], 0);
      chk("R8", "other tx_ready", s_tx_r[1-own], 0);
      chk("R8", "other rx_valid", s_rx_v[1-own], 0);
      chk("R8", "other done_valid", s_dn_v[1-own], 0);
    end
  endtask

  // drive one sync-response beat (plus a receive beat) toward the owner
  task automatic done_beat(input int own, input logic [7:0] val, input string req);
    e_dn_v = 1'b1; e_dn_d = val;
    e_rx_v = 1'b1; e_rx_d = {val, ~val};
    s_dn_r[own] = 1'b1; s_rx_r[own] = 1'b1;
    chk_owner(own, req);
    chk("R7", "owner done_data", s_dn_d[own], val);
    chk("R7", "owner rx_data", s_rx_d[own], {val, ~val});
    step();
    e_dn_v = 1'b0; e_rx_v = 1'b0;
    s_dn_r[own] = 1'b0; s_rx_r[own] = 1'b0;
  endtask

  initial begin
    clear_srcs();
    // R1: reset with a request pending
    s_cmd_v[1] = 1'b1; s_cmd_d[1] = 16'h7301;
    @(negedge clk);
    step(); step();
    chk_owner(-1, "R1");
    rst_n = 1'b1;
    chk_owner(-1, "R1");
    step();
    chk_owner(1, "R2");
    // R1: reset in mid-transaction
    rst_n = 1'b0;
    step();
    chk_owner(-1, "R1");
    s_cmd_v[1] = 1'b0;
    rst_n = 1'b1;
    step();
    chk_owner(-1, "R1");

    for (int first = 0; first < 2; first++) begin
      for (int both = 0; both < 2; both++) begin
        for (int len = 1; len <= 3; len++) begin
          int win = both ? 0 : first;
          int lose = 1 - win;
          logic [7:0] tag = 8'((first << 6) | (both << 5) | (len << 2));
          clear_srcs();
          s_cmd_v[win] = 1'b1; s_cmd_d[win] = {4'h7, 4'h3, tag};
          if (both != 0) begin
            s_cmd_v[lose] = 1'b1; s_cmd_d[lose] = {4'b0011, 4'h0, ~tag};
            s_tx_v[lose] = 1'b1; s_tx_d[lose] = 8'h80;
          end
          chk_owner(-1, "R2");
          step();
          // R2 R3: granted the cycle after the request
          for (int k = 0; k < len; k++) begin
            s_cmd_d[win] = {(k % 2 == 1) ? 4'h2 : 4'h7, 4'h3, tag | 8'(k)};
            s_tx_v[win] = 1'b1; s_tx_d[win] = 8'h40 + 8'(k);
            chk_owner(win, (k == 0) ? (both != 0 ? "R3" : "R2") : "R4");
            step();
          end
          // R5: stray sync response before any sync command keeps the grant
          s_cmd_v[win] = 1'b0; s_tx_v[win] = 1'b0;
          done_beat(win, 8'h55 ^ tag, "R5");
          chk_owner(win, "R5");
          // sync command accepted
          s_cmd_v[win] = 1'b1; s_cmd_d[win] = {4'b0011, 4'h1, tag};
          chk_owner(win, "R5");
          step();
          s_cmd_v[win] = 1'b0;
          chk_owner(win, "R5");
          step();
          chk_owner(win, "R5");
          // R6: completion releases at this edge
          done_beat(win, 8'hA0 ^ tag, "R6");
          chk_owner(-1, "R6");
          step();
          if (both != 0) begin
            chk_owner(lose, "R3");
            step();
            s_cmd_v[lose] = 1'b0; s_tx_v[lose] = 1'b0;
            chk_owner(lose, "R4");
            done_beat(lose, 8'h3C ^ tag, "R6");
            chk_owner(-1, "R6");
            step();
          end
          chk_owner(-1, "R1");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule